// File: doc/BRIEF.md
# Frame and Superframe Sync Detector

This block watches a stream of received four-level line symbols and finds where each 120-symbol frame begins. Two 9-symbol marker words are recognised: a normal word that opens ordinary frames, and its sign-flipped twin that opens the first frame of every eight-frame superframe. A match of either word while searching fixes a candidate frame position. Further matches at the expected spacing confirm it. Once locked, the block rides through short bursts of damaged markers and gives up only after a run of consecutive misses.

With frame lock held, the block looks for the inverted word on a strict eight-frame cadence to establish superframe lock. It then reports which frame of the superframe is in progress. Downstream logic uses the position counter and the start pulses to demultiplex channels. It uses the lock flags to decide whether the recovered data can be trusted.

Top module: `frame_sync_detector`

## Requirements
- R1: After reset, symCount is 0, frameStart, superStart, frameLock and superLock are low, frameIndex is 0, and the 8-symbol history behind the incoming symbol holds -3 symbols.
- R2: Each accepted symbol (symValid high) advances symCount by one, wrapping from 119 to 0. Cycles with symValid low change no state, and both pulses are low after such a cycle.
- R3: Symbols are coded sign-then-magnitude: 2'b10 = +3, 2'b11 = +1, 2'b01 = -1, 2'b00 = -3. The normal word, oldest first, is +3 +3 -3 -3 -3 +3 -3 +3 +3. The inverted word is the same with every sign flipped. Each word is matched against the incoming symbol and the eight symbols before it. While searching, a match of either word sets symCount to 8 and starts confirmation.
- R4: A symbol that lands at position 8 (symCount was 7) is a slot symbol. During confirmation, a match of either word on the slot symbol counts as a hit, and frameLock rises on the second such hit. A slot symbol without a match returns the block to search. Matches away from the slot are ignored once searching has ended.
- R5: While locked, three consecutive slot symbols without a match drop frameLock. Any matching slot symbol resets the miss run.
- R6: frameStart is high for exactly one cycle after each slot symbol that leaves frameLock high. At that point symCount reads 8.
- R7: The first inverted word at a slot arms the superframe counter at frame 0. An inverted word exactly eight frames after the armed frame 0 sets superLock. Slots without any match still advance the frame count.
- R8: While armed, a normal word where the inverted word is expected clears superLock and disarms. An inverted word anywhere else clears superLock and restarts the count at frame 0.
- R9: frameIndex gives the frame number 0..7 within the superframe while superLock is high and reads 0 otherwise. superStart pulses together with frameStart when superLock is held and frameIndex is 0.
- R10: Losing frame lock clears superLock and the armed state in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| symValid | input | 1 | Strobe marking a new symbol on symIn |
| symIn | input | 2 | Received symbol, sign bit then magnitude bit |
| symCount | output | 7 | Position of the last accepted symbol in the frame |
| frameStart | output | 1 | One-cycle pulse after a locked slot symbol |
| superStart | output | 1 | One-cycle pulse at the start of a locked superframe |
| frameLock | output | 1 | Frame alignment held |
| superLock | output | 1 | Superframe alignment held |
| frameIndex | output | 3 | Frame within the superframe, valid with superLock |

## Verification
The assertions assume that symIn and symValid are known on every clock after reset. They also assume that a symbol is accepted only on cycles where symValid is high, with any number of idle cycles allowed between symbols. The stimulus always drives one of the four legal codes and inserts idle cycles at random. It mixes well-formed frame sequences, deliberately corrupted marker slots, misplaced normal and inverted words, and long runs of unstructured random symbols. This exercises every state while keeping the inputs fully defined.

// File: rtl/sync_det_pkg.sv
package sync_det_pkg;
  localparam int SYM_W    = 2;
  localparam int SYNC_LEN = 9;
  localparam int WORD_W   = SYM_W * SYNC_LEN;

  // oldest symbol in the most significant pair; +3 = 2'b10, -3 = 2'b00
  localparam logic [WORD_W-1:0] NORM_WORD = 18'b10_10_00_00_00_10_00_10_10;
  localparam logic [WORD_W-1:0] INV_WORD  = 18'b00_00_10_10_10_00_10_00_00;

  typedef struct packed {
    logic realign;
  } ctrlStrobe_t;

  typedef struct packed {
    logic normHit;
    logic invHit;
    logic slotEdge;
  } dpFlags_t;
endpackage

// File: rtl/sync_det_dp.sv
module sync_det_dp
  import sync_det_pkg::*;
#(
  parameter int FRAME_LEN = 120,
  localparam int CNT_W = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             symValid,
  input  logic [SYM_W-1:0] symIn,
  input  ctrlStrobe_t      ctrl,
  output dpFlags_t         flags,
  output logic [CNT_W-1:0] symCount
);
  localparam int HIST_W = SYM_W * (SYNC_LEN - 1);

  logic [HIST_W-1:0] hist;
  logic [WORD_W-1:0] window;

  assign window = {hist, symIn};

  always_comb begin
    flags.normHit  = symValid && (window == NORM_WORD);
    flags.invHit   = symValid && (window == INV_WORD);
    flags.slotEdge = symValid && (symCount == CNT_W'(SYNC_LEN - 2));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hist     <= '0;
      symCount <= '0;
    end else if (symValid) begin
      hist <= window[HIST_W-1:0];
      if (ctrl.realign)
        symCount <= CNT_W'(SYNC_LEN - 1);
      else if (symCount == CNT_W'(FRAME_LEN - 1))
        symCount <= '0;
      else
        symCount <= symCount + 1'b1;
    end
  end
endmodule

// File: rtl/sync_det_ctrl.sv
module sync_det_ctrl
  import sync_det_pkg::*;
#(
  parameter int CONFIRM_HITS = 2,
  parameter int LOSS_MISSES  = 3,
  parameter int SF_FRAMES    = 8,
  localparam int HIT_W  = $clog2(CONFIRM_HITS + 1),
  localparam int MISS_W = $clog2(LOSS_MISSES + 1),
  localparam int IDX_W  = $clog2(SF_FRAMES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpFlags_t         flags,
  output ctrlStrobe_t      ctrl,
  output logic             frameStart,
  output logic             superStart,
  output logic             frameLock,
  output logic             superLock,
  output logic [IDX_W-1:0] frameIndex
);
  typedef enum logic [1:0] {ST_SEARCH, ST_CONFIRM, ST_LOCKED} syncState_t;

  syncState_t        st, stNext;
  logic [HIT_W-1:0]  hits, hitsNext;
  logic [MISS_W-1:0] misses, missesNext;
  logic [IDX_W-1:0]  idx, idxNext, idxInc;
  logic              armed, armedNext, slNext;
  logic              anyHit, lockNext, slotLocked, boundary;

  assign anyHit = flags.normHit || flags.invHit;

  // frame alignment state
  always_comb begin
    stNext       = st;
    hitsNext     = hits;
    missesNext   = misses;
    ctrl.realign = (st == ST_SEARCH) && anyHit;
    case (st)
      ST_SEARCH: if (anyHit) begin
        stNext   = ST_CONFIRM;
        hitsNext = '0;
      end
      ST_CONFIRM: if (flags.slotEdge) begin
        if (!anyHit) stNext = ST_SEARCH;
        else if (hits == HIT_W'(CONFIRM_HITS - 1)) begin
          stNext     = ST_LOCKED;
          missesNext = '0;
        end else hitsNext = hits + 1'b1;
      end
      default: if (flags.slotEdge) begin
        if (anyHit) missesNext = '0;
        else if (misses == MISS_W'(LOSS_MISSES - 1)) stNext = ST_SEARCH;
        else missesNext = misses + 1'b1;
      end
    endcase
  end

  assign lockNext   = (stNext == ST_LOCKED);
  assign slotLocked = flags.slotEdge && lockNext;
  assign boundary   = armed && (idx == IDX_W'(SF_FRAMES - 1));
  assign idxInc     = (idx == IDX_W'(SF_FRAMES - 1)) ? '0 : idx + 1'b1;

  // superframe cadence
  always_comb begin
    armedNext = armed;
    idxNext   = idx;
    slNext    = superLock;
    if (!lockNext) begin
      armedNext = 1'b0;
      idxNext   = '0;
      slNext    = 1'b0;
    end else if (slotLocked) begin
      if (flags.invHit) begin
        idxNext   = '0;
        armedNext = 1'b1;
        slNext    = armed && boundary;
      end else if (flags.normHit && boundary) begin
        armedNext = 1'b0;
        idxNext   = '0;
        slNext    = 1'b0;
      end else if (armed) begin
        idxNext = idxInc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st         <= ST_SEARCH;
      hits       <= '0;
      misses     <= '0;
      idx        <= '0;
      armed      <= 1'b0;
      superLock  <= 1'b0;
      frameStart <= 1'b0;
      superStart <= 1'b0;
    end else begin
      st         <= stNext;
      hits       <= hitsNext;
      misses     <= missesNext;
      idx        <= idxNext;
      armed      <= armedNext;
      superLock  <= slNext;
      frameStart <= slotLocked;
      superStart <= slotLocked && slNext && (idxNext == '0);
    end
  end

  assign frameLock  = (st == ST_LOCKED);
  assign frameIndex = superLock ? idx : '0;
endmodule

// File: rtl/frame_sync_detector.sv
module frame_sync_detector
  import sync_det_pkg::*;
#(
  parameter int FRAME_LEN    = 120,
  parameter int CONFIRM_HITS = 2,
  parameter int LOSS_MISSES  = 3,
  parameter int SF_FRAMES    = 8,
  localparam int CNT_W = $clog2(FRAME_LEN),
  localparam int IDX_W = $clog2(SF_FRAMES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             symValid,
  input  logic [1:0]       symIn,
  output logic [CNT_W-1:0] symCount,
  output logic             frameStart,
  output logic             superStart,
  output logic             frameLock,
  output logic             superLock,
  output logic [IDX_W-1:0] frameIndex
);
  ctrlStrobe_t ctrl;
  dpFlags_t    flags;

  sync_det_dp #(.FRAME_LEN(FRAME_LEN)) i_dp (
    .clk(clk), .rstN(rstN), .symValid(symValid), .symIn(symIn),
    .ctrl(ctrl), .flags(flags), .symCount(symCount)
  );

  sync_det_ctrl #(
    .CONFIRM_HITS(CONFIRM_HITS), .LOSS_MISSES(LOSS_MISSES), .SF_FRAMES(SF_FRAMES)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .flags(flags), .ctrl(ctrl),
    .frameStart(frameStart), .superStart(superStart), .frameLock(frameLock),
    .superLock(superLock), .frameIndex(frameIndex)
  );
endmodule

// File: rtl/sync_det_checks.sv
module sync_det_checks #(
  parameter int FRAME_LEN = 120,
  parameter int CNT_W     = 7,
  parameter int IDX_W     = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             symValid,
  input logic [CNT_W-1:0] symCount,
  input logic             frameStart,
  input logic             superStart,
  input logic             frameLock,
  input logic             superLock,
  input logic [IDX_W-1:0] frameIndex
);
  assert_count_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    symCount < CNT_W'(FRAME_LEN));
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !symValid |=> $stable(symCount) && !frameStart);
  assert_lock_at_slot_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameLock) |-> frameStart);
  assert_pulse_locked_R6: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> frameLock && symCount == CNT_W'(8));
  assert_super_needs_frame_R10: assert property (@(posedge clk) disable iff (!rstN)
    superLock |-> frameLock);
  assert_index_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !superLock |-> frameIndex == '0);
  assert_super_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    superStart |-> frameStart && superLock && frameIndex == '0);
endmodule

bind frame_sync_detector sync_det_checks #(
  .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W), .IDX_W(IDX_W)
) i_checks (
  .clk(clk), .rstN(rstN), .symValid(symValid), .symCount(symCount),
  .frameStart(frameStart), .superStart(superStart), .frameLock(frameLock),
  .superLock(superLock), .frameIndex(frameIndex)
);

// File: tb/test_frame_sync_detector.sv
module test_frame_sync_detector;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       symValid = 1'b0;
  logic [1:0] symIn = 2'b00;
  logic [6:0] symCount;
  logic       frameStart, superStart, frameLock, superLock;
  logic [2:0] frameIndex;

  int tests = 0;
  int fails = 0;

  // reference model state
  int mHist[9];
  int mCount, mState, mHits, mMiss, mIdx;
  bit mArmed, mSl, mFs, mSs;
  int normPat[9] = '{3, 3, -3, -3, -3, 3, -3, 3, 3};

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_sync_detector i_frame_sync_detector (
    .clk(clk), .rstN(rstN), .symValid(symValid), .symIn(symIn),
    .symCount(symCount), .frameStart(frameStart), .superStart(superStart),
    .frameLock(frameLock), .superLock(superLock), .frameIndex(frameIndex)
  );

  function automatic logic [1:0] enc(int v);
    case (v)
      3:       return 2'b10;
      1:       return 2'b11;
      -1:      return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  function automatic int randSym();
    int r = int'($urandom_range(0, 3));
    return (r == 0) ? 3 : (r == 1) ? 1 : (r == 2) ? -1 : -3;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    for (int k = 0; k < 9; k++) mHist[k] = -3;
    mCount = 0; mState = 0; mHits = 0; mMiss = 0; mIdx = 0;
    mArmed = 0; mSl = 0; mFs = 0; mSs = 0;
  endtask

  task automatic modelStep(bit v, int val);
    bit isN, isI, hit, slot, lockAfter;
    if (!v) begin mFs = 0; mSs = 0; return; end
    for (int k = 0; k < 8; k++) mHist[k] = mHist[k+1];
    mHist[8] = val;
    isN = 1; isI = 1;
    for (int k = 0; k < 9; k++) begin
      if (mHist[k] != normPat[k]) isN = 0;
      if (mHist[k] != -normPat[k]) isI = 0;
    end
    hit  = isN || isI;
    slot = (mCount == 7);
    mCount = (mCount + 1) % 120;
    if (mState == 0) begin
      if (hit) begin mState = 1; mHits = 0; mCount = 8; end
    end else if (mState == 1) begin
      if (slot) begin
        if (!hit) mState = 0;
        else if (mHits == 1) begin mState = 2; mMiss = 0; end
        else mHits++;
      end
    end else if (slot) begin
      if (hit) mMiss = 0;
      else if (mMiss == 2) mState = 0;
      else mMiss++;
    end
    lockAfter = (mState == 2);
    mFs = slot && lockAfter;
    if (!lockAfter) begin
      mArmed = 0; mSl = 0; mIdx = 0;
    end else if (mFs) begin
      if (isI) begin
        mSl = mArmed && mIdx == 7;
        mArmed = 1; mIdx = 0;
      end else if (isN && mArmed && mIdx == 7) begin
        mSl = 0; mArmed = 0; mIdx = 0;
      end else if (mArmed) mIdx = (mIdx + 1) % 8;
    end
    mSs = mFs && mSl && mIdx == 0;
  endtask

  task automatic compareAll();
    chk(symCount == mCount, "R2 symCount", symCount, mCount);
    chk(frameLock == (mState == 2), "R4 R5 frameLock", frameLock, mState == 2);
    chk(frameStart == mFs, "R6 frameStart", frameStart, mFs);
    chk(superLock == mSl, "R7 R8 R10 superLock", superLock, mSl);
    chk(int'(frameIndex) == (mSl ? mIdx : 0), "R9 frameIndex", frameIndex, mSl ? mIdx : 0);
    chk(superStart == mSs, "R9 superStart", superStart, mSs);
  endtask

  task automatic sendSym(bit v, int val);
    symValid = v;
    symIn    = enc(val);
    @(posedge clk);
    #1;
    modelStep(v, val);
    compareAll();
    symValid = 1'b0;
  endtask

  task automatic sendGapped(int val);
    if ($urandom_range(0, 3) == 0) sendSym(0, randSym());
    sendSym(1, val);
  endtask

  // kind: 0 normal word, 1 inverted word, 2 damaged marker
  task automatic sendFrame(int kind);
    for (int k = 0; k < 9; k++) begin
      int s = (kind == 1) ? -normPat[k] : normPat[k];
      if (kind == 2 && k == 0) s = 1;
      sendGapped(s);
    end
    for (int k = 9; k < 120; k++) sendGapped(randSym());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    modelReset();
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk(symCount == 0, "R1 symCount", symCount, 0);
    chk(!frameLock && !superLock, "R1 locks", frameLock + superLock, 0);
    chk(!frameStart && !superStart, "R1 pulses", frameStart + superStart, 0);
    chk(frameIndex == 0, "R1 frameIndex", frameIndex, 0);

    // R2 idle cycles hold state
    for (int k = 0; k < 30; k++) sendGapped(randSym());
    for (int k = 0; k < 4; k++) sendSym(0, 3);

    // R3 R4 R7 acquire frame then superframe
    for (int f = 0; f < 20; f++) sendFrame(((f + 5) % 8 == 0) ? 1 : 0);
    chk(frameLock == 1, "R4 locked after sequence", frameLock, 1);
    chk(superLock == 1, "R7 superframe locked", superLock, 1);

    // R5 two damaged markers keep lock, three drop it
    sendFrame(2); sendFrame(2);
    chk(frameLock == 1, "R5 lock held over two misses", frameLock, 1);
    sendFrame(0); sendFrame(2); sendFrame(2); sendFrame(2);
    chk(frameLock == 0, "R5 lock lost after three misses", frameLock, 0);
    chk(superLock == 0, "R10 superLock cleared with frame lock", superLock, 0);

    // R8 normal word where the inverse is due
    for (int j = 0; j < 13; j++) sendFrame((j == 4 || j == 12) ? 1 : 0);
    chk(superLock == 1, "R7 relock", superLock, 1);
    for (int j = 13; j < 20; j++) sendFrame(0);
    chk(int'(frameIndex) == 7, "R9 index before boundary", frameIndex, 7);
    sendFrame(0);
    chk(superLock == 0, "R8 normal at boundary", superLock, 0);

    // R8 inverted word out of cadence
    sendFrame(0); sendFrame(1);
    for (int j = 0; j < 7; j++) sendFrame(0);
    sendFrame(1);
    chk(superLock == 1, "R7 cadence relock", superLock, 1);
    sendFrame(0); sendFrame(0); sendFrame(1);
    chk(superLock == 0, "R8 early inverse", superLock, 0);

    // unstructured random symbols
    for (int k = 0; k < 3000; k++) sendGapped(randSym());

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule